// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block places one boundary-scan cell on every pin of a small core: one cell for each input pin and one for each output pin. Each cell has a shift stage and an update stage. The shift stages are joined into one serial path that runs from `scan_in` to `scan_out`. Several instances can therefore be daisy-chained, so that a longer path spans more than one core.

An external test controller drives the block with four plain single-cycle strobes, all sampled on `clk`:

- `dr_clock` clocks the shift stages. `dr_shift` chooses what they load on that edge: serial data, or the cell's parallel input.
- `dr_update` copies every shift stage into its update stage.
- `tlr_clr` clears the update stages.

The level input `test_mode` selects what drives the pins and the core. When it is 0, functional data passes straight through each cell. When it is 1, the update stages drive the outputs instead.

A controller uses the block in two ways. For sample/preload, it keeps `test_mode` at 0, captures the pin values, shifts them out and loads new values into the update stages. For external test, it raises `test_mode` so that the preloaded values drive the core side and the pad side.

The serial data and the strobes carry no back-pressure. Each strobe acts on exactly the edge where it is high, so there is no valid/ready pair.

Top module: `bscan_chain`

## Requirements
- R1: With `test_mode` = 0, `core_in` equals `pin_in` and `pin_out` equals `core_out`, combinationally.
- R2: An edge with `dr_clock` = 1 and `dr_shift` = 0 loads each cell's shift stage from its parallel input. Input cells load from `pin_in`. Output cells load from `core_out`.
- R3: An edge with `dr_clock` = 1 and `dr_shift` = 1 moves every shift stage one cell toward `scan_out`. Cell 0 takes `scan_in`. `scan_out` is the shift stage of the last cell, so a bit entering at `scan_in` appears at `scan_out` after N strobes.
- R4: While `dr_clock` is 0, no shift stage changes. This holds whatever `dr_shift`, `dr_update`, `test_mode` and the data inputs do.
- R5: A `dr_update` edge copies every shift stage into its update stage. With `test_mode` = 1, each cell's output shows its update stage.
- R6: The update stages hold between `dr_update` pulses. With `test_mode` = 1, the outputs stay stable while shifting continues.
- R7: An active-low `rst_n` clears all stages. A `tlr_clr` edge clears the update stages and takes priority over `dr_update`. After either, the outputs are all 0 when `test_mode` = 1.
- R8: A preload made with `test_mode` = 0 leaves the outputs passing functional data. Raising `test_mode` afterwards makes the preloaded values appear at once, with no further strobe.
- R9: When two instances are chained, they form one serial path whose length is the sum of their cell counts. A stream shifted in comes back out in the same order.
- R10: Cells are numbered 0..N-1 from `scan_in`, with N = N_IN + N_OUT. Cell i < N_IN serves input pin i. Cell i ≥ N_IN serves output pin i − N_IN. After N shift strobes, the k-th bit shifted in (counting from 0) sits in cell N−1−k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low test reset |
| tlr_clr | input | 1 | Synchronous clear of the update stages |
| dr_shift | input | 1 | 1: shift stages load serially; 0: they capture parallel data |
| dr_clock | input | 1 | Shift-stage clock enable strobe |
| dr_update | input | 1 | Update strobe |
| test_mode | input | 1 | 1: update stages drive the outputs |
| scan_in | input | 1 | Serial input to cell 0 |
| scan_out | output | 1 | Serial output from the last cell |
| pin_in | input | N_IN | Values at the input pads |
| core_in | output | N_IN | Values presented to the core inputs |
| core_out | input | N_OUT | Values produced by the core outputs |
| pin_out | output | N_OUT | Values driven onto the output pads |

## Verification
The bench builds two instances. The first uses the defaults, N_IN = 3 and N_OUT = 8. The second is mirrored, with N_IN = 8 and N_OUT = 3, and its input pads are wired to the first instance's output pads. Their serial ports are joined into one 22-cell path.

This mirrored pairing means one stream crosses both input-cell and output-cell mappings, including the instance boundary. The bench can therefore check the placement of every bit position across the whole path. It can also check captures taken from pins that one instance's pass-through drives.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef struct packed {
    logic shift;   // serial load select
    logic clock;   // shift stage enable
    logic update;  // update stage enable
    logic clr;     // update stage clear
    logic mode;    // test data select
  } bs_ctrl_t;

endpackage

// File: rtl/bscan_sel.sv
module bscan_sel #(
  parameter int W = 1
) (
  input  logic         sel,
  input  logic [W-1:0] func_d,
  input  logic [W-1:0] test_d,
  output logic [W-1:0] y
);
  always_comb begin
    y = sel ? test_d : func_d;
  end
endmodule

// File: rtl/bscan_cell.sv
module bscan_cell
  import bscan_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bs_ctrl_t ctrl,
  input  logic     par_in,
  input  logic     ser_in,
  output logic     ser_out,
  output logic     par_out
);
  logic shift_q;
  logic upd_q;

  // capture / shift stage: moves only on a clock strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= 1'b0;
    end else if (ctrl.clock) begin
      shift_q <= ctrl.shift ? ser_in : par_in;
    end
  end

  // update stage: clear wins over update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
    end else if (ctrl.clr) begin
      upd_q <= 1'b0;
    end else if (ctrl.update) begin
      upd_q <= shift_q;
    end
  end

  assign ser_out = shift_q;

  bscan_sel #(.W(1)) u_sel (
    .sel    (ctrl.mode),
    .func_d (par_in),
    .test_d (upd_q),
    .y      (par_out)
  );
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int N_IN  = 3,
  parameter int N_OUT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tlr_clr,
  input  logic             dr_shift,
  input  logic             dr_clock,
  input  logic             dr_update,
  input  logic             test_mode,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] pin_out
);
  localparam int N = N_IN + N_OUT;

  bs_ctrl_t   ctrl;
  logic [N:0] link;   // link[i] feeds cell i, link[N] is the chain output

  always_comb begin
    ctrl.shift  = dr_shift;
    ctrl.clock  = dr_clock;
    ctrl.update = dr_update;
    ctrl.clr    = tlr_clr;
    ctrl.mode   = test_mode;
  end

  assign link[0]  = scan_in;
  assign scan_out = link[N];

  for (genvar i = 0; i < N; i++) begin : g_cell
    if (i < N_IN) begin : g_in
      bscan_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    (ctrl),
        .par_in  (pin_in[i]),
        .ser_in  (link[i]),
        .ser_out (link[i+1]),
        .par_out (core_in[i])
      );
    end else begin : g_out
      bscan_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    (ctrl),
        .par_in  (core_out[i-N_IN]),
        .ser_in  (link[i]),
        .ser_out (link[i+1]),
        .par_out (pin_out[i-N_IN])
      );
    end
  end
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int N_IN  = 3,
  parameter int N_OUT = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tlr_clr,
  input logic                   dr_shift,
  input logic                   dr_clock,
  input logic                   dr_update,
  input logic                   test_mode,
  input logic                   scan_out,
  input logic [N_IN-1:0]        pin_in,
  input logic [N_IN-1:0]        core_in,
  input logic [N_OUT-1:0]       core_out,
  input logic [N_OUT-1:0]       pin_out,
  input logic [N_IN+N_OUT:0]    link
);
  localparam int N = N_IN + N_OUT;

  p_mode0_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> (core_in == pin_in) && (pin_out == core_out));

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dr_clock && !dr_shift |=> scan_out == $past(core_out[N_OUT-1]));

  p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dr_clock && dr_shift |=> scan_out == $past(link[N-1]));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_clock |=> $stable(scan_out));

  p_upd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !dr_update && !tlr_clr) ##1 test_mode
      |-> $stable(pin_out) && $stable(core_in));

  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tlr_clr ##1 test_mode |-> (pin_out == '0) && (core_in == '0));
endmodule

bind bscan_chain bscan_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tlr_clr   (tlr_clr),
  .dr_shift  (dr_shift),
  .dr_clock  (dr_clock),
  .dr_update (dr_update),
  .test_mode (test_mode),
  .scan_out  (scan_out),
  .pin_in    (pin_in),
  .core_in   (core_in),
  .core_out  (core_out),
  .pin_out   (pin_out),
  .link      (link)
);

// File: tb/bscan_chain_bench.sv
module bscan_chain_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tlr_clr = 1'b0, dr_shift = 1'b0, dr_clock = 1'b0, dr_update = 1'b0;
  logic test_mode = 1'b0, scan_in = 1'b0;
  logic so_a, so_b;
  logic [2:0] pin_in_a, core_in_a, core_out_b, pin_out_b;
  logic [7:0] core_out_a, pin_out_a, core_in_b;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bscan_chain #(.N_IN(3), .N_OUT(8)) u_bscan_chain (
    .clk(clk), .rst_n(rst_n), .tlr_clr(tlr_clr), .dr_shift(dr_shift),
    .dr_clock(dr_clock), .dr_update(dr_update), .test_mode(test_mode),
    .scan_in(scan_in), .scan_out(so_a), .pin_in(pin_in_a), .core_in(core_in_a),
    .core_out(core_out_a), .pin_out(pin_out_a));

  bscan_chain #(.N_IN(8), .N_OUT(3)) u_bscan_chain_b (
    .clk(clk), .rst_n(rst_n), .tlr_clr(tlr_clr), .dr_shift(dr_shift),
    .dr_clock(dr_clock), .dr_update(dr_update), .test_mode(test_mode),
    .scan_in(so_a), .scan_out(so_b), .pin_in(pin_out_a), .core_in(core_in_b),
    .core_out(core_out_b), .pin_out(pin_out_b));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // global cell g: 0..10 first instance, 11..21 second instance
  task automatic scan22(input logic [21:0] vin, output logic [21:0] vout);
    for (int k = 0; k < 22; k++) begin
      @(negedge clk);
      vout[21-k] = so_b;
      scan_in  = vin[21-k];
      dr_shift = 1'b1;
      dr_clock = 1'b1;
      @(negedge clk);
      dr_clock = 1'b0;
    end
  endtask

  task automatic capture();
    @(negedge clk); dr_shift = 1'b0; dr_clock = 1'b1;
    @(negedge clk); dr_clock = 1'b0;
  endtask

  task automatic update();
    @(negedge clk); dr_update = 1'b1;
    @(negedge clk); dr_update = 1'b0;
  endtask

  function automatic logic [21:0] outs();
    return {pin_out_b, core_in_b, pin_out_a, core_in_a};
  endfunction

  task automatic t_reset_r7();
    @(negedge clk); test_mode = 1'b1; #1;
    chk("R7 reset outputs", {10'b0, outs()}, 32'h0);
    @(negedge clk); test_mode = 1'b0;
  endtask

  task automatic t_pass_r1();
    for (int p = 0; p < 2; p++) begin
      @(negedge clk);
      pin_in_a = p ? 3'b010 : 3'b101; core_out_a = p ? 8'h3C : 8'hC3; core_out_b = p ? 3'b001 : 3'b110;
      #1;
      chk("R1 core_in a", {29'b0, core_in_a}, {29'b0, pin_in_a});
      chk("R1 pin_out a", {24'b0, pin_out_a}, {24'b0, core_out_a});
      chk("R1 core_in b", {24'b0, core_in_b}, {24'b0, core_out_a});
      chk("R1 pin_out b", {29'b0, pin_out_b}, {29'b0, core_out_b});
    end
  endtask

  task automatic t_capture_r2();
    logic [21:0] got;
    @(negedge clk); pin_in_a = 3'b101; core_out_a = 8'hA5; core_out_b = 3'b110;
    capture();
    scan22(22'h0, got);
    chk("R2 capture stream", {10'b0, got}, {10'b0, 3'b110, 8'hA5, 8'hA5, 3'b101});
  endtask

  task automatic t_shift_r3_r4_r9();
    logic [21:0] got;
    logic s0;
    scan22(22'h2B_C61D, got);
    chk("R3 first bit at scan_out", {31'b0, so_b}, {31'b0, 1'b1}); // bit 21 of pattern
    s0 = so_b;
    // R4: no clock strobe; toggle everything else
    @(negedge clk); dr_shift = 1'b0; scan_in = ~scan_in; dr_update = 1'b1;
    pin_in_a = ~pin_in_a; core_out_a = ~core_out_a; core_out_b = ~core_out_b;
    @(negedge clk); dr_update = 1'b0; dr_shift = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 scan_out held", {31'b0, so_b}, {31'b0, s0});
    scan22(22'h0, got);
    chk("R9 22-bit round trip", {10'b0, got}, {10'b0, 22'h2B_C61D});
  endtask

  task automatic t_update_r5_r10_r6();
    logic [21:0] got;
    scan22(22'h35_A5C3, got);
    update();
    @(negedge clk); test_mode = 1'b1; #1;
    chk("R5 outputs show update stages", {10'b0, outs()}, {10'b0, 22'h35_A5C3});
    chk("R10 cell 0 -> core_in a[0]", {31'b0, core_in_a[0]}, 32'h1);
    chk("R10 cell 21 -> pin_out b[2]", {31'b0, pin_out_b[2]}, 32'h1);
    scan22(22'h0A_1234, got);
    chk("R6 outputs hold while shifting", {10'b0, outs()}, {10'b0, 22'h35_A5C3});
    update(); #1;
    chk("R5 second update", {10'b0, outs()}, {10'b0, 22'h0A_1234});
  endtask

  task automatic t_tlr_r7();
    @(negedge clk); tlr_clr = 1'b1; dr_update = 1'b1;
    @(negedge clk); tlr_clr = 1'b0; dr_update = 1'b0; #1;
    chk("R7 clear beats update", {10'b0, outs()}, 32'h0);
    @(negedge clk); test_mode = 1'b0;
  endtask

  task automatic t_preload_r8();
    logic [21:0] got;
    @(negedge clk); pin_in_a = 3'b011; core_out_a = 8'h5A; core_out_b = 3'b100;
    scan22(22'h1F_0F0F, got);
    update(); #1;
    chk("R8 preload keeps pass-through", {10'b0, outs()},
        {10'b0, 3'b100, 8'h5A, 8'h5A, 3'b011});
    @(negedge clk); test_mode = 1'b1; #1;
    chk("R8 preload revealed", {10'b0, outs()}, {10'b0, 22'h1F_0F0F});
    @(negedge clk); test_mode = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    pin_in_a = '0; core_out_a = '0; core_out_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_r7();
    t_pass_r1();
    t_capture_r2();
    t_shift_r3_r4_r9();
    t_update_r5_r10_r6();
    t_tlr_r7();
    t_preload_r8();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule